// File: doc/BRIEF.md
# Data Lane Low-Power Control Decoder

This block follows the two single-ended low-power line levels of one serial data lane and works out which control-mode request the far end is making. The levels arrive already synchronised to the system clock, as one bit for the positive line and one for the negative line. Starting from the idle stop level (both lines high), the block recognises three request sequences. It raises a one-cycle pulse for each one and moves its mode output to match: high-speed entry, escape entry or bus turnaround.

After an escape entry the block collects an eight-bit entry command sent with spaced-one-hot signalling. Each mark level carries one bit and is followed by a space level with both lines low. Two command codes are parameters: one enters the ultra-low-power state and one enters low-power data transfer. Any other code is reported as a command error. The ultra-low-power state is left by a wakeup: the positive line rises, and after a programmable number of cycles both lines go high. Line levels that do not fit the sequence under way raise an error pulse. The block then ignores the lane until the stop level returns.

Top module: `lp_lane_ctrl`

## Requirements
- R1: While and directly after reset, mode is 0 (stop), every pulse output is 0 and cmd_byte is 0.
- R2: The line level is {lp_dp, lp_dn}. Only a change of that level counts as an event, and a level that is held for any number of cycles is one event. Outputs are registered and respond on the second rising clock edge after a new level is presented.
- R3: From stop, the levels 01 then 00 pulse hs_req and set mode 1 (high speed). In mode 1, every level except 11 is ignored, and 11 returns mode to 0.
- R4: From stop, the levels 10, 00, 01, 00 pulse esc_req and set mode 2 (escape command reception).
- R5: From stop, the levels 10, 00, 10, 00 pulse bta_req and set mode 3 (turnaround). In mode 3, every level except 11 is ignored, and 11 returns mode to 0.
- R6: In mode 2, a mark of 10 is a 1 bit and a mark of 01 is a 0 bit, and each mark is followed by a 00 space. Bits arrive least significant first. On the space after the eighth bit, cmd_valid pulses and cmd_byte takes the assembled byte, which it holds until the next command.
- R7: A command equal to ULPS_CODE (default 8'h1E) pulses ulps_enter and sets mode 5. A command equal to LPDT_CODE (default 8'hE1) sets mode 4. Any other command pulses cmd_err and sets mode 6 (recovery).
- R8: In mode 4, marks and spaces alternate freely. A mark of 10 followed by 11 is an escape exit and returns mode to 0 with no error.
- R9: In mode 5, the level 10 starts a wakeup. If 10 is held for N cycles and then 11 arrives, ulps_exit pulses when N >= wake_limit, and wake_err pulses otherwise. Either way mode returns to 0.
- R10: A level that does not fit the sequence under way pulses seq_err. Mode goes to 0 if that level is 11, and to 6 otherwise. In mode 6 every level except 11 is ignored, and 11 returns mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_dp | input | 1 | Synchronised low-power level of the positive line |
| lp_dn | input | 1 | Synchronised low-power level of the negative line |
| wake_limit | input | WAKE_W | Minimum wakeup duration in clock cycles |
| mode | output | 3 | 0 stop, 1 high speed, 2 escape command, 3 turnaround, 4 low-power data, 5 ultra-low-power, 6 recovery |
| hs_req | output | 1 | Pulse on a high-speed entry request |
| esc_req | output | 1 | Pulse on an escape entry request |
| bta_req | output | 1 | Pulse on a turnaround request |
| cmd_valid | output | 1 | Pulse when an entry command is complete |
| cmd_byte | output | CMD_W | Last decoded entry command |
| ulps_enter | output | 1 | Pulse on entry to the ultra-low-power state |
| ulps_exit | output | 1 | Pulse on a correctly timed wakeup |
| seq_err | output | 1 | Pulse on an illegal level sequence |
| cmd_err | output | 1 | Pulse on an unrecognised entry command |
| wake_err | output | 1 | Pulse on a wakeup that was too short |

## Verification
A wrong internal sequence state shows up at the mode output, or as a missing or extra request pulse. This happens two edges after the level that should have moved it, because every level change is checked on the cycle it is decoded. A corrupted bit count or shift register stays hidden until the eighth space, and then shows up as a wrong cmd_byte or a spurious cmd_err. A wrong wakeup count shows up only when 11 arrives, so the bench places the wakeup hold exactly at the limit and one cycle short of it.

// File: rtl/lp_lane_pkg.sv
package lp_lane_pkg;
  localparam logic [1:0] LV00 = 2'b00;
  localparam logic [1:0] LV01 = 2'b01;
  localparam logic [1:0] LV10 = 2'b10;
  localparam logic [1:0] LV11 = 2'b11;

  typedef enum logic [3:0] {
    ST_STOP, ST_H01, ST_A10, ST_A00, ST_E01, ST_T10,
    ST_HS, ST_TURN, ST_ESC, ST_LPDT, ST_ULPS, ST_WAKE, ST_WAIT
  } seq_state_t;

  typedef enum logic [2:0] {
    MD_STOP = 3'd0, MD_HS = 3'd1, MD_ESC = 3'd2, MD_TURN = 3'd3,
    MD_LPDT = 3'd4, MD_ULPS = 3'd5, MD_RECOVER = 3'd6
  } lane_mode_t;

  function automatic lane_mode_t mode_of(seq_state_t s);
    case (s)
      ST_HS:            return MD_HS;
      ST_TURN:          return MD_TURN;
      ST_ESC:           return MD_ESC;
      ST_LPDT:          return MD_LPDT;
      ST_ULPS, ST_WAKE: return MD_ULPS;
      ST_WAIT:          return MD_RECOVER;
      default:          return MD_STOP;
    endcase
  endfunction
endpackage

// File: rtl/lp_line_sampler.sv
module lp_line_sampler (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_in,
  output logic [1:0] cur_lv,
  output logic [1:0] prev_lv,
  output logic       lv_chg
);
  import lp_lane_pkg::*;
  logic [1:0] cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= LV11;
      prev_q <= LV11;
    end else begin
      cur_q  <= line_in;
      prev_q <= cur_q;
    end
  end

  assign cur_lv  = cur_q;
  assign prev_lv = prev_q;
  assign lv_chg  = (cur_q != prev_q);
endmodule

// File: rtl/lp_esc_shift.sv
module lp_esc_shift #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_val,
  output logic [CMD_W-1:0] shreg,
  output logic             full
);
  localparam int NB_W = $clog2(CMD_W + 1);
  logic [CMD_W-1:0] sh_q;
  logic [NB_W-1:0]  nb_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q <= '0;
      nb_q <= '0;
    end else if (bit_vld) begin
      sh_q <= {bit_val, sh_q[CMD_W-1:1]};
      nb_q <= nb_q + 1'b1;
    end
  end

  assign shreg = sh_q;
  assign full  = (nb_q == NB_W'(CMD_W));

  // R6
  bit_count_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !clr) |=> (nb_q == $past(nb_q) + 1'b1));
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer #(
  parameter int WAKE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              en,
  input  logic [WAKE_W-1:0] limit,
  output logic              done
);
  localparam logic [WAKE_W-1:0] CNT_MAX = '1;
  logic [WAKE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= WAKE_W'(1);
    else if (en && cnt_q != CNT_MAX)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q >= limit);

  // R9
  wake_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && $past(en)) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/lp_ctrl_fsm.sv
module lp_ctrl_fsm #(
  parameter int               CMD_W     = 8,
  parameter logic [CMD_W-1:0] ULPS_CODE = 8'h1E,
  parameter logic [CMD_W-1:0] LPDT_CODE = 8'hE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cur_lv,
  input  logic [1:0]       prev_lv,
  input  logic             lv_chg,
  input  logic [CMD_W-1:0] sh_byte,
  input  logic             sh_full,
  input  logic             tmr_done,
  output logic             sh_clr,
  output logic             sh_vld,
  output logic             sh_bit,
  output logic             tmr_load,
  output logic             tmr_en,
  output logic [2:0]       mode,
  output logic             hs_req,
  output logic             esc_req,
  output logic             bta_req,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_byte,
  output logic             ulps_enter,
  output logic             ulps_exit,
  output logic             seq_err,
  output logic             cmd_err,
  output logic             wake_err
);
  import lp_lane_pkg::*;

  seq_state_t       state_q, state_n;
  lane_mode_t       mode_q;
  logic [CMD_W-1:0] byte_q, byte_n;
  logic hs_n, esc_n, bta_n, cv_n, ue_n, ux_n, cerr_n, werr_n, bad;

  always_comb begin
    state_n = state_q;
    byte_n  = byte_q;
    {hs_n, esc_n, bta_n, cv_n, ue_n, ux_n, cerr_n, werr_n, bad} = '0;
    sh_clr = 1'b0; sh_vld = 1'b0; sh_bit = 1'b0; tmr_load = 1'b0;
    if (lv_chg) begin
      case (state_q)
        ST_STOP:
          if (cur_lv == LV01)      state_n = ST_H01;
          else if (cur_lv == LV10) state_n = ST_A10;
          else                     bad = 1'b1;
        ST_H01:
          if (cur_lv == LV00) begin state_n = ST_HS; hs_n = 1'b1; end
          else bad = 1'b1;
        ST_A10:
          if (cur_lv == LV00) state_n = ST_A00;
          else bad = 1'b1;
        ST_A00:
          if (cur_lv == LV01)      state_n = ST_E01;
          else if (cur_lv == LV10) state_n = ST_T10;
          else                     bad = 1'b1;
        ST_E01:
          if (cur_lv == LV00) begin
            state_n = ST_ESC; esc_n = 1'b1; sh_clr = 1'b1;
          end else bad = 1'b1;
        ST_T10:
          if (cur_lv == LV00) begin state_n = ST_TURN; bta_n = 1'b1; end
          else bad = 1'b1;
        ST_HS, ST_TURN, ST_WAIT:
          if (cur_lv == LV11) state_n = ST_STOP;
        ST_ESC:
          if (prev_lv == LV00) begin
            if (cur_lv == LV11) bad = 1'b1;
            else begin sh_vld = 1'b1; sh_bit = (cur_lv == LV10); end
          end else if (cur_lv == LV00) begin
            if (sh_full) begin
              cv_n   = 1'b1;
              byte_n = sh_byte;
              if (sh_byte == ULPS_CODE) begin state_n = ST_ULPS; ue_n = 1'b1; end
              else if (sh_byte == LPDT_CODE) state_n = ST_LPDT;
              else begin state_n = ST_WAIT; cerr_n = 1'b1; end
            end
          end else bad = 1'b1;
        ST_LPDT:
          if (prev_lv == LV00) begin
            if (cur_lv == LV11) bad = 1'b1;
          end else if (cur_lv == LV00) begin
            state_n = ST_LPDT;
          end else if (prev_lv == LV10 && cur_lv == LV11) begin
            state_n = ST_STOP;
          end else bad = 1'b1;
        ST_ULPS:
          if (cur_lv == LV10) begin state_n = ST_WAKE; tmr_load = 1'b1; end
          else bad = 1'b1;
        ST_WAKE:
          if (cur_lv == LV11) begin
            state_n = ST_STOP;
            if (tmr_done) ux_n = 1'b1;
            else          werr_n = 1'b1;
          end else bad = 1'b1;
        default: state_n = ST_STOP;
      endcase
      if (bad) state_n = (cur_lv == LV11) ? ST_STOP : ST_WAIT;
    end
  end

  assign tmr_en = (state_q == ST_WAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_STOP;
      mode_q  <= MD_STOP;
      byte_q  <= '0;
      {hs_req, esc_req, bta_req, cmd_valid, ulps_enter, ulps_exit,
       seq_err, cmd_err, wake_err} <= '0;
    end else begin
      state_q    <= state_n;
      mode_q     <= mode_of(state_n);
      byte_q     <= byte_n;
      hs_req     <= hs_n;
      esc_req    <= esc_n;
      bta_req    <= bta_n;
      cmd_valid  <= cv_n;
      ulps_enter <= ue_n;
      ulps_exit  <= ux_n;
      seq_err    <= bad;
      cmd_err    <= cerr_n;
      wake_err   <= werr_n;
    end
  end

  assign mode     = mode_q;
  assign cmd_byte = byte_q;

  // R2
  hold_no_event_chk: assert property (@(posedge clk) disable iff (rst)
    !lv_chg |=> $stable(mode_q));
  // R3
  hs_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
    hs_req |-> ($past(mode_q) == MD_STOP && mode_q == MD_HS));
  // R6
  cmd_in_escape_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($past(mode_q) == MD_ESC));
  // R9
  wake_from_ulps_chk: assert property (@(posedge clk) disable iff (rst)
    (ulps_exit || wake_err) |-> ($past(mode_q) == MD_ULPS && mode_q == MD_STOP));
  // R10
  recover_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_RECOVER) |=> (mode_q == MD_RECOVER || mode_q == MD_STOP));
  // R10
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hs_req, esc_req, bta_req, ulps_exit, seq_err, cmd_err, wake_err}));
endmodule

// File: rtl/lp_lane_ctrl.sv
module lp_lane_ctrl #(
  parameter int               CMD_W     = 8,
  parameter int               WAKE_W    = 20,
  parameter logic [CMD_W-1:0] ULPS_CODE = 8'h1E,
  parameter logic [CMD_W-1:0] LPDT_CODE = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_dp,
  input  logic              lp_dn,
  input  logic [WAKE_W-1:0] wake_limit,
  output logic [2:0]        mode,
  output logic              hs_req,
  output logic              esc_req,
  output logic              bta_req,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_byte,
  output logic              ulps_enter,
  output logic              ulps_exit,
  output logic              seq_err,
  output logic              cmd_err,
  output logic              wake_err
);
  logic [1:0]       cur_lv, prev_lv;
  logic             lv_chg, sh_clr, sh_vld, sh_bit, sh_full;
  logic             tmr_load, tmr_en, tmr_done;
  logic [CMD_W-1:0] sh_byte;

  lp_line_sampler u_samp (
    .clk(clk), .rst(rst), .line_in({lp_dp, lp_dn}),
    .cur_lv(cur_lv), .prev_lv(prev_lv), .lv_chg(lv_chg)
  );

  lp_esc_shift #(.CMD_W(CMD_W)) u_shift (
    .clk(clk), .rst(rst), .clr(sh_clr), .bit_vld(sh_vld),
    .bit_val(sh_bit), .shreg(sh_byte), .full(sh_full)
  );

  lp_wake_timer #(.WAKE_W(WAKE_W)) u_wake (
    .clk(clk), .rst(rst), .load(tmr_load), .en(tmr_en),
    .limit(wake_limit), .done(tmr_done)
  );

  lp_ctrl_fsm #(.CMD_W(CMD_W), .ULPS_CODE(ULPS_CODE), .LPDT_CODE(LPDT_CODE)) u_fsm (
    .clk(clk), .rst(rst), .cur_lv(cur_lv), .prev_lv(prev_lv), .lv_chg(lv_chg),
    .sh_byte(sh_byte), .sh_full(sh_full), .tmr_done(tmr_done),
    .sh_clr(sh_clr), .sh_vld(sh_vld), .sh_bit(sh_bit),
    .tmr_load(tmr_load), .tmr_en(tmr_en),
    .mode(mode), .hs_req(hs_req), .esc_req(esc_req), .bta_req(bta_req),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ulps_enter(ulps_enter),
    .ulps_exit(ulps_exit), .seq_err(seq_err), .cmd_err(cmd_err), .wake_err(wake_err)
  );
endmodule

// File: tb/lp_lane_ctrl_bench.sv
module lp_lane_ctrl_bench;
  localparam int WAKE_W = 20;
  localparam logic [7:0] C_ULPS = 8'h1E;
  localparam logic [7:0] C_LPDT = 8'hE1;
  localparam int LIMIT = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lp_dp = 1'b1, lp_dn = 1'b1;
  logic [WAKE_W-1:0] wake_limit = WAKE_W'(LIMIT);
  logic [2:0] mode;
  logic hs_req, esc_req, bta_req, cmd_valid, ulps_enter, ulps_exit;
  logic seq_err, cmd_err, wake_err;
  logic [7:0] cmd_byte;

  always #2 clk = ~clk;

  lp_lane_ctrl u_lp_lane_ctrl (
    .clk(clk), .rst(rst), .lp_dp(lp_dp), .lp_dn(lp_dn), .wake_limit(wake_limit),
    .mode(mode), .hs_req(hs_req), .esc_req(esc_req), .bta_req(bta_req),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ulps_enter(ulps_enter),
    .ulps_exit(ulps_exit), .seq_err(seq_err), .cmd_err(cmd_err), .wake_err(wake_err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference model
  localparam int P_STOP = 0, P_HS = 1, P_ESC = 2, P_TURN = 3, P_LPDT = 4,
                 P_ULPS = 5, P_WAKE = 6, P_REC = 7;
  int ph = P_STOP, nb = 0, wcnt = 0;
  logic [1:0] mq = 2'b11, mp = 2'b11;
  logic [1:0] hist[$];
  logic [1:0] pat_hs[$]  = '{2'b01, 2'b00};
  logic [1:0] pat_esc[$] = '{2'b10, 2'b00, 2'b01, 2'b00};
  logic [1:0] pat_bta[$] = '{2'b10, 2'b00, 2'b10, 2'b00};
  logic [7:0] sh = 0, e_byte = 0;
  logic [2:0] e_mode = 0;
  bit e_hs, e_esc, e_bta, e_cv, e_ue, e_ux, e_seq, e_cerr, e_werr;

  function automatic bit is_prefix(logic [1:0] h[$], logic [1:0] p[$]);
    if (h.size() > p.size()) return 0;
    foreach (h[i]) if (h[i] != p[i]) return 0;
    return 1;
  endfunction

  function automatic logic [2:0] mode_for(int p);
    case (p)
      P_HS: return 3'd1;  P_ESC: return 3'd2;  P_TURN: return 3'd3;
      P_LPDT: return 3'd4; P_ULPS, P_WAKE: return 3'd5; P_REC: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  task automatic fault(logic [1:0] v);
    e_seq = 1;
    ph = (v == 2'b11) ? P_STOP : P_REC;
    hist.delete();
  endtask

  task automatic model_step(logic [1:0] din);
    logic [1:0] v, pv;
    v = mq; pv = mp;
    {e_hs, e_esc, e_bta, e_cv, e_ue, e_ux, e_seq, e_cerr, e_werr} = '0;
    if (v != pv) begin
      case (ph)
        P_STOP: begin
          hist.push_back(v);
          if (hist == pat_hs) begin e_hs = 1; ph = P_HS; hist.delete(); end
          else if (hist == pat_esc) begin e_esc = 1; ph = P_ESC; nb = 0; sh = 0; hist.delete(); end
          else if (hist == pat_bta) begin e_bta = 1; ph = P_TURN; hist.delete(); end
          else if (!(is_prefix(hist, pat_hs) || is_prefix(hist, pat_esc) || is_prefix(hist, pat_bta)))
            fault(v);
        end
        P_HS, P_TURN, P_REC: if (v == 2'b11) ph = P_STOP;
        P_ESC: begin
          if (pv == 2'b00) begin
            if (v == 2'b11) fault(v);
            else begin sh = {v == 2'b10, sh[7:1]}; nb++; end
          end else if (v == 2'b00) begin
            if (nb == 8) begin
              e_cv = 1; e_byte = sh;
              if (sh == C_ULPS) begin e_ue = 1; ph = P_ULPS; end
              else if (sh == C_LPDT) ph = P_LPDT;
              else begin e_cerr = 1; ph = P_REC; end
            end
          end else fault(v);
        end
        P_LPDT: begin
          if (pv == 2'b00) begin if (v == 2'b11) fault(v); end
          else if (v == 2'b00) ;
          else if (pv == 2'b10 && v == 2'b11) ph = P_STOP;
          else fault(v);
        end
        P_ULPS: if (v == 2'b10) begin ph = P_WAKE; wcnt = 1; end else fault(v);
        P_WAKE: begin
          if (v == 2'b11) begin
            if (wcnt >= LIMIT) e_ux = 1; else e_werr = 1;
            ph = P_STOP;
          end else fault(v);
        end
        default: ph = P_STOP;
      endcase
    end else if (ph == P_WAKE) wcnt++;
    e_mode = mode_for(ph);
    mp = mq; mq = din;
  endtask

  task automatic chk(string nm, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("mode", 8'(mode), 8'(e_mode));
    chk("hs_req", 8'(hs_req), 8'(e_hs));
    chk("esc_req", 8'(esc_req), 8'(e_esc));
    chk("bta_req", 8'(bta_req), 8'(e_bta));
    chk("cmd_valid", 8'(cmd_valid), 8'(e_cv));
    chk("cmd_byte", cmd_byte, e_byte);
    chk("ulps_enter", 8'(ulps_enter), 8'(e_ue));
    chk("ulps_exit", 8'(ulps_exit), 8'(e_ux));
    chk("seq_err", 8'(seq_err), 8'(e_seq));
    chk("cmd_err", 8'(cmd_err), 8'(e_cerr));
    chk("wake_err", 8'(wake_err), 8'(e_werr));
  endtask

  task automatic tick(logic [1:0] din);
    {lp_dp, lp_dn} = din;
    model_step(din);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic hold(logic [1:0] din, int n);
    for (int i = 0; i < n; i++) tick(din);
  endtask

  task automatic send_cmd(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      hold(b[i] ? 2'b10 : 2'b01, 2);
      hold(2'b00, 2);
    end
  endtask

  task automatic esc_entry();
    hold(2'b10, 2); hold(2'b00, 3); hold(2'b01, 1); hold(2'b00, 2);
  endtask

  int hs_seen = 0;
  always @(posedge clk) if (!rst && hs_req) hs_seen++;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    chk("mode_reset", 8'(mode), 8'd0);
    rst = 1'b0;
    hold(2'b11, 4);

    // R3 with R2: long dwell and ignored levels inside high speed
    cur_req = "R3";
    hold(2'b01, 5); hold(2'b00, 7); hold(2'b01, 3); hold(2'b10, 2); hold(2'b00, 4); hold(2'b11, 3);
    cur_req = "R2";
    chk("hs_count", 8'(hs_seen), 8'd1);

    // R5 turnaround
    cur_req = "R5";
    hold(2'b10, 1); hold(2'b00, 1); hold(2'b10, 1); hold(2'b00, 3); hold(2'b01, 2); hold(2'b11, 3);

    // R4, R6, R7, R9: ULPS with correct wakeup at the limit boundary
    cur_req = "R4"; esc_entry();
    cur_req = "R6"; send_cmd(C_ULPS);
    cur_req = "R9"; hold(2'b00, 5); hold(2'b10, LIMIT); hold(2'b11, 3);
    // R9: one cycle short
    cur_req = "R7"; esc_entry(); send_cmd(C_ULPS);
    cur_req = "R9"; hold(2'b10, LIMIT - 1); hold(2'b11, 3);
    chk("cmd_byte_hold", cmd_byte, C_ULPS);

    // R8: low-power data then escape exit
    cur_req = "R8"; esc_entry(); send_cmd(C_LPDT);
    send_cmd(8'h5A); hold(2'b10, 2); hold(2'b11, 3);
    chk("mode_after_exit", 8'(mode), 8'd0);

    // R7: unknown command then recovery
    cur_req = "R7"; esc_entry(); send_cmd(8'h33);
    hold(2'b10, 2); hold(2'b11, 3);

    // R10: assorted illegal sequences
    cur_req = "R10";
    hold(2'b00, 3); hold(2'b01, 2); hold(2'b10, 2); hold(2'b11, 2);
    hold(2'b10, 2); hold(2'b11, 2);
    hold(2'b10, 1); hold(2'b00, 1); hold(2'b11, 2);
    hold(2'b01, 2); hold(2'b10, 2); hold(2'b11, 2);
    esc_entry(); hold(2'b10, 2); hold(2'b00, 2); hold(2'b10, 2); hold(2'b11, 3);
    esc_entry(); send_cmd(C_LPDT); hold(2'b10, 2); hold(2'b01, 2); hold(2'b11, 3);
    esc_entry(); send_cmd(C_ULPS); hold(2'b01, 2); hold(2'b11, 3);
    esc_entry(); send_cmd(C_ULPS); hold(2'b10, 4); hold(2'b00, 2); hold(2'b11, 3);

    cur_req = "R6"; esc_entry(); send_cmd(8'hFF); hold(2'b11, 2);
    cur_req = "R6"; esc_entry(); send_cmd(8'h00); hold(2'b11, 2);
    chk("cmd_byte_zero", cmd_byte, 8'h00);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule